// File: doc/BRIEF.md
# Flash Read Timing Sequencer

This block turns a CPU read request into the timed strobe sequence that a flash bank needs. It drives a bank clock and a bank enable, holds the read address steady, waits the programmed number of wait states and then returns the read data with a ready pulse. The block runs on a clock at twice the system rate. A phase input, `sys_rise`, is high on every fast cycle whose rising edge coincides with a system-clock rising edge, and it alternates every fast cycle. This gives the sequencer half-system-cycle resolution for the bank clock.

An eight-bit configuration word sets four fields. Bits 3:0 give the wait-state count. Bit 4 selects the data path: 0 registers the flash data, 1 passes it straight through. Bit 5 selects the clock sense. Bits 7:6 set the bank-clock high time. The sequencer copies the word when it accepts a request, so a change to the word only affects the next read. The expected setting for a stacked part at 120 MHz has bits 4:3 at zero and bits 6:5 equal to 01, which is 8'h20.

The CPU holds `rd_req` high until it sees `rd_ready`. It then drops the request before the next system rising edge. The flash array is outside the block: it sees `bank_clk`, `bank_en` and `bank_addr`, and it returns `bank_rdata`.

States: IDLE (waiting), SKEW (half-cycle delay for fall-aligned sense), HIGH (bank clock high), LOW (wait states), ALIGN (wait for a system rising edge), HOLD (the extra system cycle in registered mode), DATA (ready window). Transitions: IDLE→HIGH or IDLE→SKEW on accept; SKEW→HIGH; HIGH→LOW when wait states are nonzero, otherwise HIGH→ALIGN; LOW→ALIGN when the count is spent; ALIGN→DATA (bypass) or ALIGN→HOLD (registered) on a system rising edge; HOLD→DATA and DATA→IDLE on a system rising edge.

Top module: `flrd_seq`

## Requirements
- R1: During reset and right after it, `bank_clk`, `bank_en` and `rd_ready` are low and `rd_data` is zero.
- R2: A read is accepted only at a fast edge where `sys_rise` and `rd_req` are both high and the sequencer is idle. `bank_en` is high from the fast cycle after acceptance through the last ready cycle. During that time `bank_addr` holds the address captured at acceptance.
- R3: With cfg bit 5 = 0, `bank_clk` is high in the fast cycle that begins at the accepting edge. With bit 5 = 1, it goes high one fast cycle (half a system cycle) later.
- R4: Each read gives exactly one bank-clock pulse. The pulse lasts (cfg[7:6]+1) fast cycles: 00 gives half a system cycle, 01 one cycle, 10 one and a half cycles, 11 two cycles.
- R5: After the pulse, `bank_clk` stays low for 2×cfg[3:0] fast cycles (0 to 15 system cycles) before the access is complete.
- R6: With cfg bit 4 = 1, ready starts at the first system rising edge after the access completes. With bit 4 = 0, it starts one system cycle after that edge, and the flash data is captured on that edge.
- R7: `rd_ready` is high for exactly two fast cycles (one system cycle) per read. `rd_data` carries the read data then and is zero at all other times.
- R8: A request seen while the sequencer is busy starts nothing. Changes to `rd_addr` during a read are ignored. The next read can start at the first system rising edge after the sequencer has returned to idle.
- R9: A change to `cfg_word` after acceptance does not alter the timing or data path of the read in progress.
- R10: In bypass mode `rd_data` follows `bank_rdata` directly during the ready window. In registered mode it shows the value captured on the alignment edge, even if `bank_rdata` changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the system rate |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_rise | input | 1 | High on fast cycles aligned to system rising edges |
| cfg_word | input | 8 | Timing configuration: high time, sense, data path, wait states |
| rd_req | input | 1 | CPU read request, held until ready |
| rd_addr | input | AW | CPU read address |
| rd_ready | output | 1 | Read complete, one system cycle wide |
| rd_data | output | DW | Read data, zero outside the ready window |
| bank_clk | output | 1 | Flash bank clock |
| bank_en | output | 1 | Flash bank enable for the whole read |
| bank_addr | output | AW | Address presented to the flash bank |
| bank_rdata | input | DW | Data returned by the flash bank |

## Verification
The bench builds the block with AW = 20, DW = 32 and a 4-bit wait-state field. With these values it can sweep every high-time code, both senses, both data paths and wait counts from 0 up to the maximum of 15. Its flash model shows valid data only from the end of the wait states up to just after the sampling point, and it shows a poison word outside that span. A capture on the wrong edge or a bypass read outside its window therefore gives wrong data. Dedicated reads change the configuration and the address in mid-read, and keep the request high while the sequencer is busy.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

    localparam int HT_W   = 2;
    localparam int WS_W   = 4;
    localparam int CFG_W  = HT_W + 2 + WS_W;

    // Field order is the register layout: [7:6] high time, [5] sense,
    // [4] bypass, [3:0] wait states.
    typedef struct packed {
        logic [HT_W-1:0] hi_time;
        logic            fall_sense;
        logic            bypass;
        logic [WS_W-1:0] waits;
    } rd_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKEW,
        ST_HIGH,
        ST_LOW,
        ST_ALIGN,
        ST_HOLD,
        ST_DATA
    } seq_state_t;

endpackage

// File: rtl/flrd_down_cnt.sv
module flrd_down_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/flrd_fsm.sv
module flrd_fsm
    import flrd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sys_rise,
    input  logic    rd_req,
    input  rd_cfg_t cfg_in,
    output rd_cfg_t cfg_q,
    output logic    accept,
    output logic    capture,
    output logic    bank_clk,
    output logic    busy,
    output logic    ready
);
    localparam int CNT_W = WS_W + 1;

    seq_state_t state_q, state_d;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    flrd_down_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // state and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) cfg_q <= cfg_in;
        end
    end

    // next state and counter control
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sys_rise && rd_req) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(cfg_in.hi_time);
                    state_d  = cfg_in.fall_sense ? ST_SKEW : ST_HIGH;
                end
            end
            ST_SKEW: state_d = ST_HIGH;
            ST_HIGH: begin
                if (cnt_zero) begin
                    if (cfg_q.waits == '0) begin
                        state_d = ST_ALIGN;
                    end else begin
                        cnt_load = 1'b1;
                        cnt_val  = {cfg_q.waits, 1'b0} - 1'b1;
                        state_d  = ST_LOW;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt_zero) state_d = ST_ALIGN;
                else          cnt_dec = 1'b1;
            end
            ST_ALIGN: begin
                if (sys_rise) begin
                    capture = 1'b1;
                    state_d = cfg_q.bypass ? ST_DATA : ST_HOLD;
                end
            end
            ST_HOLD: if (sys_rise) state_d = ST_DATA;
            ST_DATA: if (sys_rise) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        bank_clk = (state_q == ST_HIGH);
        busy     = (state_q != ST_IDLE);
        ready    = (state_q == ST_DATA);
    end

    // R9: configuration copy frozen while a read runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cfg_q));

    // R5: wait-state phase only entered with a nonzero count
    a_r5_low_needs_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (cfg_q.waits != '0));

    // R3: the skew phase always leads into the high phase
    a_r3_skew_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKEW) |=> (state_q == ST_HIGH));

endmodule

// File: rtl/flrd_datapath.sv
module flrd_datapath #(
    parameter int AW = 20,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          ready,
    input  logic          bypass,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] bank_rdata,
    output logic [AW-1:0] bank_addr,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (accept)  addr_q <= rd_addr;
            if (capture) data_q <= bank_rdata;
        end
    end

    always_comb begin
        bank_addr = addr_q;
        if (!ready)      rd_data = '0;
        else if (bypass) rd_data = bank_rdata;
        else             rd_data = data_q;
    end

endmodule

// File: rtl/flrd_seq.sv
module flrd_seq
    import flrd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rise,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_ready,
    output logic [DW-1:0]    rd_data,
    output logic             bank_clk,
    output logic             bank_en,
    output logic [AW-1:0]    bank_addr,
    input  logic [DW-1:0]    bank_rdata
);
    rd_cfg_t cfg_live, cfg_act;
    logic    accept, capture;

    assign cfg_live = rd_cfg_t'(cfg_word);

    flrd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rise (sys_rise),
        .rd_req   (rd_req),
        .cfg_in   (cfg_live),
        .cfg_q    (cfg_act),
        .accept   (accept),
        .capture  (capture),
        .bank_clk (bank_clk),
        .busy     (bank_en),
        .ready    (rd_ready)
    );

    flrd_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .ready      (rd_ready),
        .bypass     (cfg_act.bypass),
        .rd_addr    (rd_addr),
        .bank_rdata (bank_rdata),
        .bank_addr  (bank_addr),
        .rd_data    (rd_data)
    );

    // R2: a read starts only on a system rising edge
    a_r2_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_en) |-> $past(sys_rise));

    // R2: address held for the whole read
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en && $past(bank_en)) |-> $stable(bank_addr));

    // R4: bank clock only pulses inside a read
    a_r4_clk_inside_read: assert property (@(posedge clk) disable iff (!rst_n)
        bank_clk |-> bank_en);

    // R6: ready never overlaps the bank clock
    a_r6_ready_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !bank_clk);

    // R7: ready lasts exactly two fast cycles
    a_r7_ready_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |=> rd_ready);
    a_r7_ready_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && $past(rd_ready)) |=> !rd_ready);

    // R7: data bus quiet outside the ready window
    a_r7_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |-> (rd_data == '0));

endmodule

// File: tb/tb_flrd_seq.sv
module tb_flrd_seq;
    localparam int AW = 20;
    localparam int DW = 32;
    localparam logic [DW-1:0] POISON = 32'hDEAD_BEEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_rise = 1'b0;
    logic [7:0]    cfg_word = 8'h00;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_ready, bank_clk, bank_en;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bank_addr;
    logic [DW-1:0] bank_rdata = POISON;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    flrd_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .sys_rise(sys_rise), .cfg_word(cfg_word),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .bank_clk(bank_clk), .bank_en(bank_en), .bank_addr(bank_addr),
        .bank_rdata(bank_rdata)
    );

    always #5 clk = ~clk;
    always @(negedge clk) sys_rise <= ~sys_rise;

    function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
        return {a[11:0], a} ^ 32'hC3A5_5A3C;
    endfunction

    // behavioural schedule of the current read, in fast-edge indices
    int k = 0;
    int idle_from = 0;
    bit have = 1'b0;
    int k0, ts, hlen, e_acc, ra, rr, pois;
    bit byp;
    logic [AW-1:0] maddr;

    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; idle_from = 0; have = 1'b0;
        end else begin
            k = k + 1;
            if (k >= idle_from && sys_rise && rd_req) begin
                k0    = k;
                hlen  = int'(cfg_word[7:6]) + 1;
                ts    = k0 + int'(cfg_word[5]);
                e_acc = ts + hlen + 2 * int'(cfg_word[3:0]);
                ra    = (((e_acc + 1 - k0) % 2) == 0) ? e_acc + 1 : e_acc + 2;
                byp   = cfg_word[4];
                rr    = byp ? ra : ra + 2;
                pois  = byp ? ra + 2 : ra + 1;
                idle_from = rr + 3;
                maddr = rd_addr;
                have  = 1'b1;
            end
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, k, act, exp);
        end
    endtask

    // per-cycle comparison, interval after edge k
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bank_rdata = (have && k >= e_acc && k < pois) ? flash_word(bank_addr) : POISON;
            #1;
            begin
                bit x_clk, x_rdy, x_en;
                x_clk = have && k >= ts && k < ts + hlen;
                x_rdy = have && (k == rr || k == rr + 1);
                x_en  = have && k >= k0 && k <= rr + 1;
                check((have && k == k0) ? "R3" : "R4", "bank_clk", 64'(bank_clk), 64'(x_clk));
                check((have && k > ts) ? "R5" : "R6", "rd_ready", 64'(rd_ready), 64'(x_rdy));
                check("R8", "bank_en", 64'(bank_en), 64'(x_en));
                if (x_en) check("R2", "bank_addr", 64'(bank_addr), 64'(maddr));
                check(byp ? "R10" : "R7", "rd_data", 64'(rd_data),
                      x_rdy ? 64'(flash_word(maddr)) : 64'd0);
            end
        end
    end

    // one read; cfg_mid applied once the read has started (R9), addr wiggled (R8)
    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] c,
                           input logic [7:0] c_mid, input bit wiggle);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; cfg_word = c;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bank_en) break;
        end
        cfg_word = c_mid;
        if (wiggle) rd_addr = ~a;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rd_ready) break;
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!rd_ready) break;
        end
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "rst bank_clk", 64'(bank_clk), 64'd0);
        check("R1", "rst bank_en", 64'(bank_en), 64'd0);
        check("R1", "rst rd_ready", 64'(rd_ready), 64'd0);
        check("R1", "rst rd_data", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // nominal stacked setting 8'h20
        do_read(20'h12345, 8'h20, 8'h20, 1'b0);

        // R3 R4 R5 R6 R10: sweep of every field
        for (int pw = 0; pw < 4; pw++) begin
            for (int sn = 0; sn < 2; sn++) begin
                for (int bp = 0; bp < 2; bp++) begin
                    for (int wi = 0; wi < 4; wi++) begin
                        logic [3:0] ws;
                        logic [7:0] c;
                        ws = (wi == 0) ? 4'd0 : (wi == 1) ? 4'd1 : (wi == 2) ? 4'd3 : 4'd15;
                        c  = {pw[1:0], sn[0], bp[0], ws};
                        do_read(20'(pw * 4099 + sn * 513 + bp * 77 + wi * 11 + 1), c, c, 1'b0);
                        repeat (wi) @(negedge clk);
                    end
                end
            end
        end

        // R9: configuration changed in mid-read, both directions
        do_read(20'hABCDE, 8'h00, 8'hFF, 1'b0);
        do_read(20'h0F0F0, 8'hFF, 8'h00, 1'b0);
        do_read(20'h55555, 8'h13, 8'hE0, 1'b1);

        // R8: request held through a read while the address moves
        do_read(20'h7A7A7, 8'h42, 8'h42, 1'b1);
        repeat (6) @(negedge clk);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule